// File: doc/BRIEF.md
# RGB Pixel Stream Transmitter

This block feeds a passive-matrix color panel through its video-style RGB port. Pixels arrive on a valid/ready stream as 18-bit words with 6 bits per color. Each pixel goes out as three 6-bit transfers, red, then green, then blue, on the upper lines of a 9-bit panel data bus. A dot clock produced by a programmable divider of the system clock paces these transfers. The block also generates horizontal sync, vertical sync and a data-enable strobe. By default these frame a picture of 160 pixels by 128 lines.

Line and frame blanking are parameters. They are counted in dot-clock slots for a line and in whole lines for a frame. The host keeps the stream supplied. The block asks for a pixel exactly when a new active pixel starts. If none is offered at that moment, it repeats the last pixel it accepted and records an underrun. Stream rules: a pixel transfers only on a system-clock edge where both `s_valid` and `s_ready` are high. `s_ready` never depends on `s_valid`. The host may hold `s_valid` high at any time, including blanking; nothing is taken then. There is no internal buffer.

Top module: `rgb_pixel_tx`

## Requirements
- R1: `dot_clk` is low in reset, and each of its high and low phases lasts `div_half` system cycles; a `div_half` of 0 acts as 1.
- R2: A line is H_SYNC+H_BP+3*H_ACTIVE+H_FP dot slots long; a slot begins when `dot_clk` falls. `hsync` is high in the first H_SYNC slots of every line and low in all other slots.
- R3: A frame is V_SYNC+V_BP+V_ACTIVE+V_FP lines. `vsync` is high in every slot of the first V_SYNC lines and low elsewhere. The first slot after reset is slot 0 of line 0.
- R4: `de` is high only in the 3*H_ACTIVE slots that follow the first H_SYNC+H_BP slots, and only in lines V_SYNC+V_BP through V_SYNC+V_BP+V_ACTIVE-1.
- R5: Within a pixel, `s_pixel[17:12]` (red) appears on `pd[8:3]` in the first slot, `[11:6]` (green) in the second and `[5:0]` (blue) in the third. `pd[2:0]` is always 0, and `pd` is all zero in any slot where `de` is low.
- R6: `hsync`, `vsync`, `de` and `pd` change only in the system cycle in which `dot_clk` falls, so they are steady across each rising edge.
- R7: `s_ready` is high for one system cycle at a time, only in the cycle just before the slot that starts an active pixel. Exactly H_ACTIVE*V_ACTIVE pixels are accepted per frame, and `s_valid` during blanking takes nothing.
- R8: If `s_valid` is low when a pixel is requested, the last accepted pixel (0 after reset) is sent again. `underrun` then goes high and stays high until reset.
- R9: While `rst_n` is low, every output of the block is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_half | input | DIV_W | System cycles per dot-clock half period (0 acts as 1) |
| s_valid | input | 1 | Pixel stream valid |
| s_ready | output | 1 | Pixel stream ready, one-cycle pulse per active pixel |
| s_pixel | input | 3*COMP_W | Pixel word, red in the top field, blue in the bottom |
| dot_clk | output | 1 | Dot clock to the panel, data sampled on its rise |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable, high on active pixel slots |
| pd | output | BUS_W | Panel data bus, color component in the top COMP_W lines |
| underrun | output | 1 | Sticky flag: a pixel was requested and none was offered |

## Verification
A corrupted slot or line counter shifts `hsync`, `vsync` and `de` away from their expected slots. This shows within one line for the horizontal count and within one frame for the vertical count. A wrong color-phase counter sends the components in the wrong order or takes pixels at the wrong moment. Both show in the next active pixel, as a `pd` value that does not match the stream, or as a per-frame accepted-pixel total different from H_ACTIVE*V_ACTIVE. A fault in the divider shows at once as wrong phase lengths of `dot_clk`. A fault in the sticky flag shows at the first starved pixel, or when the flag drops after the stream resumes.

// File: rtl/rgbtx_pkg.sv
package rgbtx_pkg;
  // Color phase inside one pixel; the order is the transmission order.
  typedef enum logic [1:0] {
    COMP_R = 2'd0,
    COMP_G = 2'd1,
    COMP_B = 2'd2
  } comp_e;
endpackage

// File: rtl/rgbtx_dotclk.sv
module rgbtx_dotclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_half,
  output logic             dot_clk,
  output logic             adv
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half_m1;
  logic             dclk_q;
  logic             expire;

  always_comb begin
    half_m1 = (div_half == '0) ? '0 : div_half - 1'b1;
    expire  = (cnt_q >= half_m1);
    adv     = expire & dclk_q;   // next edge is a falling edge
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dclk_q <= 1'b0;
    end else if (expire) begin
      cnt_q  <= '0;
      dclk_q <= ~dclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign dot_clk = dclk_q;

  p_dclk_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !expire |=> $stable(dclk_q));
  p_fall_after_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> !dclk_q);
endmodule

// File: rtl/rgbtx_timing.sv
module rgbtx_timing
  import rgbtx_pkg::*;
#(
  parameter int H_ACTIVE = 160,
  parameter int V_ACTIVE = 128,
  parameter int H_SYNC   = 2,
  parameter int H_BP     = 3,
  parameter int H_FP     = 3,
  parameter int V_SYNC   = 1,
  parameter int V_BP     = 2,
  parameter int V_FP     = 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  output logic  hs,
  output logic  vs,
  output logic  de,
  output logic  nxt_de,
  output comp_e nxt_comp
);
  localparam int H_START = H_SYNC + H_BP;
  localparam int H_END   = H_START + 3 * H_ACTIVE;
  localparam int H_TOTAL = H_END + H_FP;
  localparam int V_START = V_SYNC + V_BP;
  localparam int V_END   = V_START + V_ACTIVE;
  localparam int V_TOTAL = V_END + V_FP;
  localparam int HW      = (H_TOTAL > 2) ? $clog2(H_TOTAL) : 1;
  localparam int VW      = (V_TOTAL > 2) ? $clog2(V_TOTAL) : 1;

  logic [HW-1:0] h_q, h_n;
  logic [VW-1:0] v_q, v_n;
  comp_e         c_q, c_n;
  logic          hs_q, vs_q, de_q;
  logic          h_wrap, h_act_n, v_act_n;

  always_comb begin
    h_wrap  = (h_q == HW'(H_TOTAL - 1));
    h_n     = h_wrap ? '0 : h_q + 1'b1;
    if (h_wrap) v_n = (v_q == VW'(V_TOTAL - 1)) ? '0 : v_q + 1'b1;
    else        v_n = v_q;
    h_act_n = (h_n >= HW'(H_START)) && (h_n < HW'(H_END));
    v_act_n = (v_n >= VW'(V_START)) && (v_n < VW'(V_END));
    if (h_n == HW'(H_START))  c_n = COMP_R;
    else if (c_q == COMP_B)   c_n = COMP_R;
    else                      c_n = comp_e'(c_q + 2'd1);
    nxt_de   = h_act_n & v_act_n;
    nxt_comp = c_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q  <= HW'(H_TOTAL - 1);
      v_q  <= VW'(V_TOTAL - 1);
      c_q  <= COMP_B;
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      de_q <= 1'b0;
    end else if (adv) begin
      h_q  <= h_n;
      v_q  <= v_n;
      c_q  <= c_n;
      hs_q <= (h_n < HW'(H_SYNC));
      vs_q <= (v_n < VW'(V_SYNC));
      de_q <= nxt_de;
    end
  end

  assign hs = hs_q;
  assign vs = vs_q;
  assign de = de_q;

  p_de_apart_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    de_q |-> (!hs_q && !vs_q));
  p_h_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    h_q <= HW'(H_TOTAL - 1));
  p_v_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    v_q <= VW'(V_TOTAL - 1));
  p_line_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && h_n == HW'(H_START)) |=> (c_q == COMP_R));
endmodule

// File: rtl/rgbtx_serializer.sv
module rgbtx_serializer
  import rgbtx_pkg::*;
#(
  parameter int COMP_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv,
  input  logic                  nxt_de,
  input  comp_e                 nxt_comp,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic [3*COMP_W-1:0]   s_pixel,
  output logic [COMP_W-1:0]     comp_out,
  output logic                  underrun
);
  localparam int PIX_W = 3 * COMP_W;

  logic [PIX_W-1:0]  pix_q, src;
  logic [COMP_W-1:0] dq, sel;
  logic              under_q, take;

  function automatic logic [COMP_W-1:0] pick(logic [PIX_W-1:0] p, comp_e c);
    case (c)
      COMP_R:  return p[PIX_W-1 -: COMP_W];
      COMP_G:  return p[2*COMP_W-1 -: COMP_W];
      default: return p[COMP_W-1:0];
    endcase
  endfunction

  always_comb begin
    take    = adv & nxt_de & (nxt_comp == COMP_R);
    s_ready = take;
    src     = (take & s_valid) ? s_pixel : pix_q;
    sel     = pick(src, nxt_comp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q   <= '0;
      dq      <= '0;
      under_q <= 1'b0;
    end else begin
      if (adv) dq <= nxt_de ? sel : '0;
      if (take && s_valid) pix_q <= s_pixel;
      if (take && !s_valid) under_q <= 1'b1;
    end
  end

  assign comp_out = dq;
  assign underrun = under_q;

  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);
  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(dq));
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    under_q |=> under_q);
  p_starve_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !s_valid) |=> under_q);
endmodule

// File: rtl/rgb_pixel_tx.sv
module rgb_pixel_tx
  import rgbtx_pkg::*;
#(
  parameter int COMP_W   = 6,
  parameter int BUS_W    = 9,
  parameter int DIV_W    = 8,
  parameter int H_ACTIVE = 160,
  parameter int V_ACTIVE = 128,
  parameter int H_SYNC   = 2,
  parameter int H_BP     = 3,
  parameter int H_FP     = 3,
  parameter int V_SYNC   = 1,
  parameter int V_BP     = 2,
  parameter int V_FP     = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DIV_W-1:0]      div_half,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic [3*COMP_W-1:0]   s_pixel,
  output logic                  dot_clk,
  output logic                  hsync,
  output logic                  vsync,
  output logic                  de,
  output logic [BUS_W-1:0]      pd,
  output logic                  underrun
);
  localparam int PAD_W = BUS_W - COMP_W;

  logic              adv, nxt_de;
  comp_e             nxt_comp;
  logic [COMP_W-1:0] comp_out;

  rgbtx_dotclk #(.DIV_W(DIV_W)) u_dclk (
    .clk(clk), .rst_n(rst_n), .div_half(div_half),
    .dot_clk(dot_clk), .adv(adv)
  );

  rgbtx_timing #(
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE),
    .H_SYNC(H_SYNC), .H_BP(H_BP), .H_FP(H_FP),
    .V_SYNC(V_SYNC), .V_BP(V_BP), .V_FP(V_FP)
  ) u_tim (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .hs(hsync), .vs(vsync), .de(de),
    .nxt_de(nxt_de), .nxt_comp(nxt_comp)
  );

  rgbtx_serializer #(.COMP_W(COMP_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .nxt_de(nxt_de), .nxt_comp(nxt_comp),
    .s_valid(s_valid), .s_ready(s_ready), .s_pixel(s_pixel),
    .comp_out(comp_out), .underrun(underrun)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign pd = {comp_out, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign pd = comp_out;
    end
  endgenerate

  p_blank_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (pd == '0));
  p_ready_in_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> dot_clk);
endmodule

// File: tb/tb_rgb_pixel_tx.sv
module tb_rgb_pixel_tx;
  localparam int HA = 4, VA = 3;
  localparam int HS = 2, HB = 3, HF = 3, VS = 1, VB = 2, VF = 1;
  localparam int H_START = HS + HB, H_TOTAL = H_START + 3*HA + HF;
  localparam int V_START = VS + VB, V_TOTAL = V_START + VA + VF;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [7:0]  div_half;
  logic        s_valid, s_ready;
  logic [17:0] s_pixel;
  logic        dot_clk, hsync, vsync, de, underrun;
  logic [8:0]  pd;

  rgb_pixel_tx #(
    .COMP_W(6), .BUS_W(9), .DIV_W(8), .H_ACTIVE(HA), .V_ACTIVE(VA),
    .H_SYNC(HS), .H_BP(HB), .H_FP(HF), .V_SYNC(VS), .V_BP(VB), .V_FP(VF)
  ) dut (
    .clk(clk), .rst_n(rst_n), .div_half(div_half), .s_valid(s_valid),
    .s_ready(s_ready), .s_pixel(s_pixel), .dot_clk(dot_clk), .hsync(hsync),
    .vsync(vsync), .de(de), .pd(pd), .underrun(underrun)
  );

  int checks = 0, failures = 0, glitch = 0, fidx = 0;
  bit took = 0, done = 0;
  logic last_dclk = 1'b0;
  logic [11:0] last_obs = '0;

  function automatic logic [17:0] pixf(int i);
    return {6'((3*i+1) % 64), 6'((3*i+2) % 64), 6'((3*i+3) % 64)};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Stream source: advance to the next pattern pixel after each transfer.
  always @(negedge clk) begin
    if (took) begin
      fidx++;
      s_pixel = pixf(fidx);
    end
    took = s_ready && s_valid;
  end

  // Wait for the next dot slot (falling dot_clk); count changes between slots.
  task automatic next_slot();
    bit found = 0;
    logic [11:0] obs;
    while (!found) begin
      @(negedge clk);
      obs = {hsync, vsync, de, pd};
      if (last_dclk && !dot_clk) found = 1;
      else if (obs !== last_obs) glitch++;
      last_dclk = dot_clk;
      last_obs  = obs;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; div_half = 8'd1; s_valid = 1'b1; fidx = 0; s_pixel = pixf(0);
    repeat (4) @(negedge clk);
    chk("R9", "outputs in reset", {26'd0, dot_clk, hsync, vsync, de, underrun, s_ready}, 32'd0);
    chk("R9", "pd in reset", {23'd0, pd}, 32'd0);
    chk("R1", "dot_clk low in reset", {31'd0, dot_clk}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_frame();
    for (int k = 0; k < H_TOTAL*V_TOTAL; k++) begin
      int line, h, a;
      bit act;
      logic [5:0] ed;
      next_slot();
      line = k / H_TOTAL; h = k % H_TOTAL;
      act = (line >= V_START) && (line < V_START+VA) && (h >= H_START) && (h < H_START+3*HA);
      ed = '0;
      if (act) begin
        a = h - H_START;
        case (a % 3)
          0: ed = pixf((line-V_START)*HA + a/3)[17:12];
          1: ed = pixf((line-V_START)*HA + a/3)[11:6];
          default: ed = pixf((line-V_START)*HA + a/3)[5:0];
        endcase
      end
      chk("R2", "hsync", {31'd0, hsync}, {31'd0, h < HS});
      chk("R3", "vsync", {31'd0, vsync}, {31'd0, line < VS});
      chk("R4", "de", {31'd0, de}, {31'd0, act});
      chk("R5", "pd", {23'd0, pd}, {23'd0, ed, 3'b000});
    end
    chk("R7", "pixels accepted per frame", fidx, HA*VA);
    chk("R8", "no underrun with full stream", {31'd0, underrun}, 32'd0);
    chk("R6", "changes off the falling edge", glitch, 0);
  endtask

  task automatic t_underrun();
    int tgt = V_START*H_TOTAL + H_START;
    logic [17:0] last = pixf(HA*VA - 1);
    s_valid = 1'b0;
    for (int k = 0; k <= tgt; k++) begin
      next_slot();
      if (k == tgt - 1) chk("R8", "underrun before starve", {31'd0, underrun}, 32'd0);
    end
    chk("R8", "underrun raised", {31'd0, underrun}, 32'd1);
    chk("R8", "repeat red", {26'd0, pd[8:3]}, {26'd0, last[17:12]});
    fidx = 100; s_pixel = pixf(100); s_valid = 1'b1;
    next_slot();
    chk("R8", "repeat green", {26'd0, pd[8:3]}, {26'd0, last[11:6]});
    next_slot();
    chk("R8", "repeat blue", {26'd0, pd[8:3]}, {26'd0, last[5:0]});
    next_slot();
    chk("R5", "fresh red after resume", {26'd0, pd[8:3]}, {26'd0, pixf(100)[17:12]});
    chk("R8", "underrun sticky", {31'd0, underrun}, 32'd1);
    chk("R6", "changes off the falling edge", glitch, 0);
  endtask

  task automatic measure(input logic [7:0] dv, input int exp);
    int hi, lo;
    logic prev;
    @(negedge clk); div_half = dv;
    prev = dot_clk;
    forever begin
      @(negedge clk);
      if (!prev && dot_clk) break;
      prev = dot_clk;
    end
    hi = 1;
    forever begin @(negedge clk); if (dot_clk) hi++; else break; end
    lo = 1;
    forever begin @(negedge clk); if (!dot_clk) lo++; else break; end
    chk("R1", "dot_clk high length", hi, exp);
    chk("R1", "dot_clk low length", lo, exp);
  endtask

  task automatic t_divider();
    measure(8'd3, 3);
    measure(8'd0, 1);
    measure(8'd2, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_frame();
    t_underrun();
    t_divider();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule